// File: doc/BRIEF.md
# Early-Exit Integer Multiply/Divide Unit

This unit does integer multiplication and division for one integer pipe. It takes two 32-bit operands, a 3-bit operation code and a one-cycle start strobe. It holds `busy_o` while it works. When it finishes, it raises `done_o` for one cycle and puts the 32-bit result on its own result port, which feeds rename storage.

Multiplication retires eight multiplier bits per step. It stops as soon as the multiplier bits still to be used carry no more information: they are all zero for an unsigned operand, or they are all copies of the sign for a signed operand. A small multiplier therefore finishes in as little as one step. A full-width multiplier takes four steps.

Division is a restoring iteration on operand magnitudes. It runs for a fixed number of steps and then takes one cycle to correct the sign. A zero divisor is caught when the operation is accepted, and the unit answers it at once.

Top module: `imuldiv_unit`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first accepted operation completes, `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: Operation codes on `op_i` are:
  - 0 gives the low 32 bits of the product.
  - 1 gives the high word of the signed product.
  - 2 gives the high word of the unsigned product.
  - 3 gives the signed quotient.
  - 4 gives the unsigned quotient.
  - Codes 5 to 7 behave as code 0.
  - Code 0 returns the low product word, which is the same for both signednesses.
- R3: Code 1 returns bits 63:32 of the two's-complement 64-bit product of the operands, both read as signed.
- R4: Code 2 returns bits 63:32 of the 64-bit product of the operands, both read as unsigned.
- R5: The number of cycles `busy_o` stays high for a multiply is the smallest k in 1..4 for which `b_i` fits in 8k bits. For codes 0, 2 and 5 to 7 this means b < 2^(8k) as an unsigned value. For code 1 it means -2^(8k-1) <= b < 2^(8k-1) as a signed value.
- R6: Division truncates toward zero. The signed quotient of 0x80000000 by 0xFFFFFFFF wraps to 0x80000000.
- R7: A divide with a nonzero divisor keeps `busy_o` high for exactly 33 cycles: 32 iterations plus one sign-correction cycle.
- R8: A divide by zero, signed or unsigned, keeps `busy_o` high for exactly 1 cycle and returns 0.
- R9: The unit accepts `start_i` only at a clock edge where `busy_o` is low. `busy_o` is high from the cycle after acceptance. `done_o` is a single-cycle pulse in the cycle in which `busy_o` has just fallen. A new operation may be accepted in that same cycle.
- R10: `start_i` while `busy_o` is high is ignored. The running operation's result and latency are unchanged, and no extra `done_o` pulse appears.
- R11: `result_o` changes only in a cycle where `done_o` is high, and it holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled when not busy |
| op_i | input | 3 | Operation code (see R2) |
| a_i | input | 32 | Multiplicand / dividend |
| b_i | input | 32 | Multiplier / divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Result, held until the next completion |

## Verification
The bench looks for the multiplier lengths at each step boundary.

Signed values such as 0x80 or 0xFFFFFF80 separate sign-copy detection from zero detection. A unit that tested only for zeros would run signed negatives to four steps. A unit that shifted logically would return wrong high words. A wrong final-chunk sign would show up in the extreme products, 0x80000000 squared and all ones squared.

Division is probed with mixed-sign operands, the most negative dividend divided by minus one, and zero divisors. A unit that mishandled these would round the wrong way, hang, or return an unchecked iteration result.

Starts pulsed mid-operation catch a unit that reloads its operands or emits a second done.

// File: rtl/imd_pkg.sv
package imd_pkg;
  localparam logic [2:0] OP_MUL   = 3'd0;
  localparam logic [2:0] OP_MULH  = 3'd1;
  localparam logic [2:0] OP_MULHU = 3'd2;
  localparam logic [2:0] OP_DIV   = 3'd3;
  localparam logic [2:0] OP_DIVU  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV,
    ST_FIX,
    ST_DZ
  } imd_state_e;
endpackage

// File: rtl/imd_decode.sv
module imd_decode
  import imd_pkg::*;
(
  input  logic [2:0] op_i,
  output logic       is_div_o,
  output logic       sgn_o,
  output logic       high_o
);
  always_comb begin
    is_div_o = 1'b0;
    sgn_o    = 1'b0;
    high_o   = 1'b0;
    case (op_i)
      OP_MULH:  begin sgn_o = 1'b1; high_o = 1'b1; end
      OP_MULHU: high_o = 1'b1;
      OP_DIV:   begin is_div_o = 1'b1; sgn_o = 1'b1; end
      OP_DIVU:  is_div_o = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/imd_mul_step.sv
// One radix-2^CHUNK step; the final chunk is taken as signed in signed mode.
module imd_mul_step #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CHUNK = 8,
  parameter int unsigned IDX_W = 6
) (
  input  logic [WIDTH:0]     mcand_i,
  input  logic [WIDTH-1:0]   mpl_i,
  input  logic               sgn_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [2*WIDTH-1:0] add_o,
  output logic               last_o,
  output logic [WIDTH-1:0]   mpl_nxt_o
);
  localparam int unsigned PW = WIDTH + CHUNK + 2;

  logic signed [CHUNK:0] chunk_s;
  logic signed [PW-1:0]  part;
  logic [2*WIDTH-1:0]    ext;
  logic                  fits_s, fits_u;

  assign fits_s = (&mpl_i[WIDTH-1:CHUNK-1]) | ~(|mpl_i[WIDTH-1:CHUNK-1]);
  assign fits_u = ~(|mpl_i[WIDTH-1:CHUNK]);
  assign last_o = sgn_i ? fits_s : fits_u;

  assign chunk_s = {last_o & sgn_i & mpl_i[CHUNK-1], mpl_i[CHUNK-1:0]};
  assign part    = PW'($signed(mcand_i)) * PW'(chunk_s);
  assign ext     = {{(2*WIDTH-PW){part[PW-1]}}, part};
  assign add_o   = ext << (idx_i * CHUNK);

  assign mpl_nxt_o = sgn_i ? WIDTH'($signed(mpl_i) >>> CHUNK) : (mpl_i >> CHUNK);
endmodule

// File: rtl/imd_div_step.sv
// One restoring-division step on magnitudes.
module imd_div_step #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem_i,
  input  logic [WIDTH-1:0] quo_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic [WIDTH-1:0] rem_o,
  output logic [WIDTH-1:0] quo_o
);
  logic [WIDTH:0] shifted, diff;
  logic           ge;

  assign shifted = {rem_i, quo_i[WIDTH-1]};
  assign diff    = shifted - {1'b0, dvs_i};
  assign ge      = ~diff[WIDTH];
  assign rem_o   = ge ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
  assign quo_o   = {quo_i[WIDTH-2:0], ge};
endmodule

// File: rtl/imuldiv_unit.sv
module imuldiv_unit
  import imd_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CHUNK = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int unsigned CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(WIDTH - 1);

  imd_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sgn_q, high_q, negq_q;
  logic [WIDTH:0]     mcand_q;
  logic [WIDTH-1:0]   mpl_q;
  logic [2*WIDTH-1:0] acc_q;
  logic [WIDTH-1:0]   rem_q, quo_q, dvs_q;
  logic               done_q;
  logic [WIDTH-1:0]   res_q;

  logic               dec_div, dec_sgn, dec_high;
  logic               accept;
  logic [WIDTH-1:0]   a_mag, b_mag;
  logic [2*WIDTH-1:0] mul_add, acc_nxt;
  logic               mul_last;
  logic [WIDTH-1:0]   mpl_nxt;
  logic [WIDTH-1:0]   rem_nxt, quo_nxt;

  imd_decode u_dec (
    .op_i    (op_i),
    .is_div_o(dec_div),
    .sgn_o   (dec_sgn),
    .high_o  (dec_high)
  );

  imd_mul_step #(.WIDTH(WIDTH), .CHUNK(CHUNK), .IDX_W(CNT_W)) u_mul (
    .mcand_i  (mcand_q),
    .mpl_i    (mpl_q),
    .sgn_i    (sgn_q),
    .idx_i    (cnt_q),
    .add_o    (mul_add),
    .last_o   (mul_last),
    .mpl_nxt_o(mpl_nxt)
  );

  imd_div_step #(.WIDTH(WIDTH)) u_div (
    .rem_i(rem_q),
    .quo_i(quo_q),
    .dvs_i(dvs_q),
    .rem_o(rem_nxt),
    .quo_o(quo_nxt)
  );

  assign accept  = start_i && (state_q == ST_IDLE);
  assign a_mag   = (dec_sgn && a_i[WIDTH-1]) ? -a_i : a_i;
  assign b_mag   = (dec_sgn && b_i[WIDTH-1]) ? -b_i : b_i;
  assign acc_nxt = acc_q + mul_add;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sgn_q   <= 1'b0;
      high_q  <= 1'b0;
      negq_q  <= 1'b0;
      mcand_q <= '0;
      mpl_q   <= '0;
      acc_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cnt_q <= '0;
            if (dec_div) begin
              if (b_i == '0) begin
                state_q <= ST_DZ;
              end else begin
                state_q <= ST_DIV;
                rem_q   <= '0;
                quo_q   <= a_mag;
                dvs_q   <= b_mag;
                negq_q  <= dec_sgn & (a_i[WIDTH-1] ^ b_i[WIDTH-1]);
              end
            end else begin
              state_q <= ST_MUL;
              sgn_q   <= dec_sgn;
              high_q  <= dec_high;
              mcand_q <= {dec_sgn & a_i[WIDTH-1], a_i};
              mpl_q   <= b_i;
              acc_q   <= '0;
            end
          end
        end
        ST_MUL: begin
          acc_q <= acc_nxt;
          mpl_q <= mpl_nxt;
          cnt_q <= cnt_q + CNT_W'(1);
          if (mul_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            res_q   <= high_q ? acc_nxt[2*WIDTH-1:WIDTH] : acc_nxt[WIDTH-1:0];
          end
        end
        ST_DIV: begin
          rem_q <= rem_nxt;
          quo_q <= quo_nxt;
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == DIV_LAST) state_q <= ST_FIX;
        end
        ST_FIX: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          res_q   <= negq_q ? -quo_q : quo_q;
        end
        ST_DZ: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          res_q   <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/imd_chk.sv
module imd_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CHUNK = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] b_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o
);
  localparam int unsigned NSTEP = WIDTH / CHUNK;
  localparam int unsigned CW    = $clog2(WIDTH + 2) + 1;

  logic          accept, op_div;
  logic          was_div_q, was_dz_q;
  logic [CW-1:0] cyc_q;

  assign accept = start_i && !busy_o;
  assign op_div = (op_i == 3'd3) || (op_i == 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      was_div_q <= 1'b0;
      was_dz_q  <= 1'b0;
      cyc_q     <= '0;
    end else if (accept) begin
      was_div_q <= op_div;
      was_dz_q  <= op_div && (b_i == '0);
      cyc_q     <= '0;
    end else if (busy_o) begin
      cyc_q <= cyc_q + CW'(1);
    end
  end

  // R9
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R9
  single_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
  // R5
  mul_steps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !was_div_q) |-> (cyc_q >= CW'(1) && cyc_q <= CW'(NSTEP)));
  // R7
  div_steps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && was_div_q && !was_dz_q) |-> (cyc_q == CW'(WIDTH + 1)));
  // R8
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && was_dz_q) |-> (cyc_q == CW'(1) && result_o == '0));
endmodule

bind imuldiv_unit imd_chk #(.WIDTH(WIDTH), .CHUNK(CHUNK)) u_imd_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .b_i     (b_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .result_o(result_o)
);

// File: tb/imuldiv_unit_bench.sv
`timescale 1ns/1ps
module imuldiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        busy_o, done_o;
  logic [31:0] result_o;

  int compared = 0;
  int mismatched = 0;
  bit ended = 1'b0;

  logic [31:0] exp_res_q[$];
  int          exp_lat_q[$];
  string       exp_tag_q[$];
  logic [31:0] seed = 32'h2545_f491;

  always #10 clk = ~clk;

  imuldiv_unit u_imuldiv_unit (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  function automatic logic [31:0] model_res(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    longint      sa = $signed(a);
    longint      sb = $signed(b);
    longint      sp;
    logic [63:0] up;
    up = {32'b0, a} * {32'b0, b};
    case (op)
      3'd1: begin sp = sa * sb; return sp[63:32]; end
      3'd2: return up[63:32];
      3'd3: begin
        if (b == 0) return 32'h0;
        sp = sa / sb;
        return sp[31:0];
      end
      3'd4: return (b == 0) ? 32'h0 : a / b;
      default: return up[31:0];
    endcase
  endfunction

  function automatic int model_lat(logic [2:0] op, logic [31:0] b);
    longint sb = $signed(b);
    if (op == 3'd3 || op == 3'd4) return (b == 0) ? 1 : 33;
    for (int k = 1; k < 4; k++) begin
      if (op == 3'd1) begin
        if (sb >= -(64'sd1 <<< (8*k-1)) && sb < (64'sd1 <<< (8*k-1))) return k;
      end else if ((b >> (8*k)) == 0) return k;
    end
    return 4;
  endfunction

  function automatic logic [31:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Driver: push expectation, pulse start once the unit is idle.
  task automatic issue(logic [2:0] op, logic [31:0] a, logic [31:0] b, string tag);
    while (busy_o) @(negedge clk);
    exp_res_q.push_back(model_res(op, a, b));
    exp_lat_q.push_back(model_lat(op, b));
    exp_tag_q.push_back(tag);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    start_i = 1'b0; a_i = next_rand(); b_i = next_rand(); op_i = 3'd3;
    check("R9 busy after start", {31'b0, busy_o}, 32'd1);
  endtask

  // Monitor / scoreboard
  int          bcnt = 0;
  bit          have_last = 1'b0;
  logic [31:0] last_res = '0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (busy_o) bcnt++;
      if (done_o) begin
        if (exp_res_q.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R10 unexpected done: actual=%h expected=none", result_o);
        end else begin
          string tg = exp_tag_q.pop_front();
          check({tg, " result"}, result_o, exp_res_q.pop_front());
          check({tg, " latency"}, bcnt, exp_lat_q.pop_front());
        end
        bcnt = 0;
        have_last = 1'b1;
        last_res = result_o;
      end else if (have_last && result_o !== last_res) begin
        check("R11 hold", result_o, last_res);
        last_res = result_o;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'b0, busy_o}, 32'd0);
    check("R1 done in reset", {31'b0, done_o}, 32'd0);
    check("R1 result in reset", result_o, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 busy after reset", {31'b0, busy_o}, 32'd0);
    check("R1 result after reset", result_o, 32'd0);

    issue(3'd0, 32'd7, 32'd6, "R2");
    issue(3'd0, 32'h1234_5678, 32'h9abc_def0, "R2");
    issue(3'd5, 32'hdead_beef, 32'h0001_0003, "R2");
    issue(3'd7, 32'hffff_ffff, 32'hffff_ffff, "R2");
    issue(3'd1, 32'hffff_ffff, 32'hffff_ffff, "R3");
    issue(3'd1, 32'h8000_0000, 32'h8000_0000, "R3");
    issue(3'd1, 32'hffff_fffb, 32'd3, "R3");
    issue(3'd1, 32'h7fff_ffff, 32'h8000_0001, "R3");
    issue(3'd2, 32'hffff_ffff, 32'hffff_ffff, "R4");
    issue(3'd2, 32'h8000_0000, 32'h0000_0002, "R4");
    issue(3'd0, 32'h1111_1111, 32'd0, "R5");
    issue(3'd2, 32'h1111_1111, 32'h0000_00ff, "R5");
    issue(3'd2, 32'h1111_1111, 32'h0000_0100, "R5");
    issue(3'd0, 32'h1111_1111, 32'h00ff_ffff, "R5");
    issue(3'd1, 32'h1234_5678, 32'h0000_0080, "R5");
    issue(3'd1, 32'h1234_5678, 32'hffff_ff80, "R5");
    issue(3'd1, 32'h1234_5678, 32'hffff_7fff, "R5");
    issue(3'd1, 32'h1234_5678, 32'h0080_0000, "R5");
    issue(3'd3, 32'd100, 32'd7, "R6");
    issue(3'd3, 32'hffff_ff9c, 32'd7, "R6");
    issue(3'd3, 32'd100, 32'hffff_fff9, "R6");
    issue(3'd3, 32'h8000_0000, 32'hffff_ffff, "R6");
    issue(3'd4, 32'hffff_ffff, 32'd3, "R7");
    issue(3'd4, 32'd5, 32'hffff_ffff, "R7");
    issue(3'd3, 32'h1234_5678, 32'd0, "R8");
    issue(3'd4, 32'hffff_ffff, 32'd0, "R8");

    // R10: pulse start mid-operation with other operands
    issue(3'd4, 32'd1000, 32'd9, "R10");
    @(negedge clk);
    start_i = 1'b1; op_i = 3'd0; a_i = 32'd3; b_i = 32'd3;
    @(negedge clk);
    start_i = 1'b0;
    issue(3'd1, 32'hdead_beef, 32'h8765_4321, "R10");
    start_i = 1'b1; op_i = 3'd3; a_i = 32'd9; b_i = 32'd0;
    @(negedge clk);
    start_i = 1'b0;

    for (int i = 0; i < 150; i++) begin
      logic [31:0] ra = next_rand();
      logic [31:0] rb = next_rand();
      logic [31:0] rs = next_rand();
      rb = (rs[5]) ? ($signed(rb) >>> rs[4:0]) : (rb >> rs[4:0]);
      if (rs[12:8] == 0) rb = 0;
      issue(3'(rs[20:16] % 5), ra, rb, (rs[20:16] % 5 > 2) ? "R6" : "R5");
    end

    while (exp_res_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    report();
  end
endmodule